// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block watches a bank of up to 64 general-purpose input lines and turns chosen edges on them into interrupt events. Every line has four per-line control and state bits: an interrupt enable, an edge-select bit, a sticky event flag and a wake enable. The pins are first brought into the clock domain through a short synchronizer. An edge is found by comparing the newest synchronized level with the sample taken one cycle before it.

Each line looks for one edge direction only. Software that needs both edges flips the edge-select bit after each event. It can read the synchronized pin levels to see which direction comes next, and to tell whether an event is real. Event flags collect whether or not the line is enabled. The enable only gates what reaches the registered parent interrupt. A separate wake output ORs the flags that have wake enabled.

All state is reached through a 32-bit register bus with a byte address. Reads are combinational and writes take effect on the clock edge. Lines 32 and above sit in the word 4 bytes above the word that holds lines 0 to 31.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After synchronous reset, enable, edge-select, event flags and wake enable are all zero, every register reads zero, and `irq_o` and `wake_o` are low.
- R2: Register words sit at byte offset 0x00 (enable), 0x08 (edge select), 0x10 (event flags), 0x18 (wake enable) and 0x20 (synchronized pin level, read-only). Bit n of the word at the base offset is line n, and bit n of base+4 is line 32+n. Enable, edge select and wake enable read back what was written, and bits for lines that do not exist read zero.
- R3: An edge-select bit of 0 sets the line's event flag on a rising edge and ignores falling edges. A bit of 1 sets it on a falling edge and ignores rising edges. A pin change applied before clock edge k shows in the flag after edge k+2.
- R4: Writing to the event-flag word clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged.
- R5: When a detected edge and a clearing write hit the same flag in the same cycle, the flag stays set.
- R6: Event flags are captured while the line's enable bit is 0.
- R7: `irq_o` is high one cycle after any line has both its flag and its enable bit set, and low one cycle after no such line remains.
- R8: `wake_o` is high in the same cycle that any line has both its flag and its wake-enable bit set.
- R9: The pin-level word returns each pin's value two clock edges after the pin changes.
- R10: Reads from unmapped or non-word-aligned offsets, and from the upper word when only one word exists, return zero. Writes there and to the pin-level word change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | NUM_LINES | Asynchronous input pin levels |
| irq_o | output | 1 | Registered parent interrupt |
| wake_o | output | 1 | Wake request |

## Verification
The bench builds the block with NUM_LINES = 40. This gives two register words, and the second word holds only eight real lines, so the masking of the missing lines 40 to 63 can be observed. Every one of the 40 lines is swept through both edge directions under both edge-select settings, checking the exact cycle of each change. The full 64-byte address window is swept for the reads that must return zero. The same-cycle collision of an event and a clear is timed on purpose, to the cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 8;

    // Address bits [7:3] choose the register, bit 2 the word.
    localparam logic [4:0] RGN_ENABLE = 5'h00;
    localparam logic [4:0] RGN_EDGE   = 5'h01;
    localparam logic [4:0] RGN_FLAG   = 5'h02;
    localparam logic [4:0] RGN_WAKE   = 5'h03;
    localparam logic [4:0] RGN_LEVEL  = 5'h04;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ENABLE,
        SEL_EDGE,
        SEL_FLAG,
        SEL_WAKE,
        SEL_LEVEL
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     word;
    } access_t;

    function automatic int words_for(input int lines);
        return (lines + WORD_W - 1) / WORD_W;
    endfunction

    function automatic access_t decode_addr(input logic [ADDR_W-1:0] addr,
                                            input int words);
        access_t r;
        r.word = addr[2];
        r.sel  = SEL_NONE;
        if (addr[1:0] == 2'b00 && int'(addr[2]) < words) begin
            case (addr[7:3])
                RGN_ENABLE: r.sel = SEL_ENABLE;
                RGN_EDGE:   r.sel = SEL_EDGE;
                RGN_FLAG:   r.sel = SEL_FLAG;
                RGN_WAKE:   r.sel = SEL_WAKE;
                RGN_LEVEL:  r.sel = SEL_LEVEL;
                default:    r.sel = SEL_NONE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge #(
    parameter int NUM_LINES   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] pin_i,
    input  logic [NUM_LINES-1:0] edge_sel_i,
    output logic [NUM_LINES-1:0] level_o,
    output logic [NUM_LINES-1:0] evt_o
);
    logic [NUM_LINES-1:0] stage [SYNC_STAGES];
    logic [NUM_LINES-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= pin_i;
    end

    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) stage[s] <= '0;
            else     stage[s] <= stage[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= stage[SYNC_STAGES-1];
    end

    assign level_o = stage[SYNC_STAGES-1];

    // Per line: select 0 looks for low-to-high, select 1 for high-to-low.
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign evt_o[i] = edge_sel_i[i] ? (prev[i] & ~level_o[i])
                                        : (level_o[i] & ~prev[i]);
    end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wen_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [WORD_W-1:0]    bus_wdata_i,
    output logic [WORD_W-1:0]    bus_rdata_o,
    input  logic [NUM_LINES-1:0] evt_i,
    input  logic [NUM_LINES-1:0] level_i,
    output logic [NUM_LINES-1:0] enable_o,
    output logic [NUM_LINES-1:0] edge_sel_o,
    output logic [NUM_LINES-1:0] flag_o,
    output logic [NUM_LINES-1:0] wake_en_o
);
    localparam int WORDS = words_for(NUM_LINES);
    localparam int PADW  = WORDS * WORD_W;

    access_t              acc;
    logic [PADW-1:0]      wmask_pad, wdata_pad, rsrc;
    logic [NUM_LINES-1:0] wmask, wbits, clr;

    assign acc = decode_addr(bus_addr_i, WORDS);

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign wmask_pad[w*WORD_W +: WORD_W] = {WORD_W{acc.word == 1'(w)}};
        assign wdata_pad[w*WORD_W +: WORD_W] = bus_wdata_i;
    end

    assign wmask = wmask_pad[NUM_LINES-1:0];
    assign wbits = wdata_pad[NUM_LINES-1:0] & wmask;
    assign clr   = (bus_wen_i && acc.sel == SEL_FLAG) ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_o   <= '0;
            edge_sel_o <= '0;
            flag_o     <= '0;
            wake_en_o  <= '0;
        end else begin
            if (bus_wen_i && acc.sel == SEL_ENABLE)
                enable_o <= (enable_o & ~wmask) | wbits;
            if (bus_wen_i && acc.sel == SEL_EDGE)
                edge_sel_o <= (edge_sel_o & ~wmask) | wbits;
            if (bus_wen_i && acc.sel == SEL_WAKE)
                wake_en_o <= (wake_en_o & ~wmask) | wbits;
            // A new edge outranks a clear of the same bit.
            flag_o <= (flag_o & ~clr) | evt_i;
        end
    end

    always_comb begin
        case (acc.sel)
            SEL_ENABLE: rsrc = PADW'(enable_o);
            SEL_EDGE:   rsrc = PADW'(edge_sel_o);
            SEL_FLAG:   rsrc = PADW'(flag_o);
            SEL_WAKE:   rsrc = PADW'(wake_en_o);
            SEL_LEVEL:  rsrc = PADW'(level_i);
            default:    rsrc = '0;
        endcase
        bus_rdata_o = '0;
        for (int w = 0; w < WORDS; w++)
            if (acc.word == 1'(w)) bus_rdata_o = rsrc[w*WORD_W +: WORD_W];
    end

    // R3: a flag may only come up where an edge was seen the cycle before.
    assert_flag_source_R3: assert property (@(posedge clk) disable iff (rst)
        (flag_o & ~$past(flag_o) & ~$past(evt_i)) == '0);

    // R4: a flag may only drop where a clearing write named it.
    assert_clear_only_by_write_R4: assert property (@(posedge clk) disable iff (rst)
        (~flag_o & $past(flag_o) & ~$past(clr)) == '0);

    // R5: every detected edge leaves its flag set, clear or not.
    assert_event_wins_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(evt_i) & ~flag_o) == '0);

endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg #(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] flag_i,
    input  logic [NUM_LINES-1:0] enable_i,
    input  logic [NUM_LINES-1:0] wake_en_i,
    output logic                 irq_o,
    output logic                 wake_o
);
    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= |(flag_i & enable_i);
    end

    assign wake_o = |(flag_i & wake_en_i);

    // R7: the parent interrupt follows enabled flags one cycle late.
    assert_irq_latency_R7: assert property (@(posedge clk) disable iff (rst)
        irq_o == $past(|(flag_i & enable_i)));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wen,
    input  logic [7:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] pin_in,
    output logic                 irq_o,
    output logic                 wake_o
);
    logic [NUM_LINES-1:0] level, evt, enable, edge_sel, flag, wake_en;

    gpio_irq_edge #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst(rst), .pin_i(pin_in), .edge_sel_i(edge_sel),
        .level_o(level), .evt_o(evt)
    );

    gpio_irq_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk(clk), .rst(rst), .bus_wen_i(bus_wen), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .evt_i(evt), .level_i(level),
        .enable_o(enable), .edge_sel_o(edge_sel), .flag_o(flag), .wake_en_o(wake_en)
    );

    gpio_irq_agg #(.NUM_LINES(NUM_LINES)) u_agg (
        .clk(clk), .rst(rst), .flag_i(flag), .enable_i(enable),
        .wake_en_i(wake_en), .irq_o(irq_o), .wake_o(wake_o)
    );

endmodule

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
    localparam int NL = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wen = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] pins = '0;
    logic          irq_o, wake_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    gpio_irq_ctrl #(.NUM_LINES(NL)) dut (
        .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pins),
        .irq_o(irq_o), .wake_o(wake_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge with the write done.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [7:0] woff(input int line);
        return (line >= 32) ? 8'h04 : 8'h00;
    endfunction

    function automatic logic [31:0] lbit(input int line);
        return 32'h1 << (line % 32);
    endfunction

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 8'h28; a += 4) begin
            rd(8'(a), v);
            chk("R1 reset read", v, 32'h0);
        end
        chk("R1 irq after reset", 32'(irq_o), 0);
        chk("R1 wake after reset", 32'(wake_o), 0);

        // R10: writes to unmapped, misaligned and level offsets change nothing
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h02, 32'hFFFF_FFFF);
        wr(8'h21, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h24, 32'hFFFF_FFFF);
        for (int a = 0; a < 64; a++) begin
            rd(8'(a), v);
            chk("R10 window sweep reads zero", v, 32'h0);
        end

        // R2: read-back of the writable words, missing lines read zero
        for (int r = 0; r < 3; r++) begin
            logic [7:0] base;
            base = (r == 0) ? 8'h00 : (r == 1) ? 8'h08 : 8'h18;
            wr(base, 32'hA5C3_0F96);
            wr(base + 8'h04, 32'hFFFF_FF5A);
            rd(base, v);          chk("R2 word0 readback", v, 32'hA5C3_0F96);
            rd(base + 8'h04, v);  chk("R2 word1 readback masked", v, 32'h0000_005A);
            wr(base, 32'h0);
            wr(base + 8'h04, 32'h0);
            rd(base, v);          chk("R2 word0 cleared", v, 32'h0);
        end

        // R3, R9: every line, both edges, both edge-select settings
        for (int i = 0; i < NL; i++) begin
            logic [7:0] fa;
            fa = 8'h10 + woff(i);
            pins[i] = 1'b1;
            @(negedge clk);
            rd(8'h20 + woff(i), v); chk("R9 level not yet", v, 32'h0);
            rd(fa, v);              chk("R3 flag not yet", v, 32'h0);
            @(negedge clk);
            rd(8'h20 + woff(i), v); chk("R9 level after two edges", v, lbit(i));
            rd(fa, v);              chk("R3 flag one edge early", v, 32'h0);
            @(negedge clk);
            rd(fa, v);              chk("R3 rising sets flag", v, lbit(i));
            wr(fa, lbit(i));
            pins[i] = 1'b0;
            repeat (4) @(negedge clk);
            rd(fa, v);              chk("R3 falling ignored with select 0", v, 32'h0);
            wr(8'h08 + woff(i), lbit(i));
            pins[i] = 1'b1;
            repeat (4) @(negedge clk);
            rd(fa, v);              chk("R3 rising ignored with select 1", v, 32'h0);
            pins[i] = 1'b0;
            repeat (4) @(negedge clk);
            rd(fa, v);              chk("R3 falling sets flag", v, lbit(i));
            wr(fa, lbit(i));
            wr(8'h08 + woff(i), 32'h0);
        end

        // R6: flags collect while enable is zero, irq stays low
        pins[3] = 1'b1; pins[35] = 1'b1;
        repeat (4) @(negedge clk);
        rd(8'h10, v); chk("R6 flag captured while disabled w0", v, 32'h8);
        rd(8'h14, v); chk("R6 flag captured while disabled w1", v, 32'h8);
        chk("R6 irq low while disabled", 32'(irq_o), 0);

        // R7: registered parent interrupt
        wr(8'h00, 32'h8);
        chk("R7 irq one cycle late", 32'(irq_o), 0);
        @(negedge clk);
        chk("R7 irq rises", 32'(irq_o), 1);

        // R8: wake aggregation
        chk("R8 wake low before enable", 32'(wake_o), 0);
        wr(8'h1C, 32'h8);
        chk("R8 wake high with flag", 32'(wake_o), 1);
        wr(8'h1C, 32'h0);
        chk("R8 wake drops", 32'(wake_o), 0);
        wr(8'h18, 32'h20);
        chk("R8 wake low without flag", 32'(wake_o), 0);

        // R7: irq falls one cycle after the enabled flag is cleared
        wr(8'h10, 32'h8);
        chk("R7 irq still high", 32'(irq_o), 1);
        @(negedge clk);
        chk("R7 irq falls", 32'(irq_o), 0);

        // R4: write-one-to-clear
        pins = '0;
        repeat (4) @(negedge clk);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        pins[7:0] = 8'hFF;
        repeat (4) @(negedge clk);
        rd(8'h10, v); chk("R4 flags set", v, 32'hFF);
        wr(8'h10, 32'h5);
        rd(8'h10, v); chk("R4 ones clear", v, 32'hFA);
        wr(8'h10, 32'h0);
        rd(8'h10, v); chk("R4 zeros leave flags", v, 32'hFA);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h10, v); chk("R4 other word untouched", v, 32'hFA);

        // R5: edge and clear in the same cycle
        pins[10] = 1'b1;
        repeat (4) @(negedge clk);
        pins[10] = 1'b0;
        repeat (4) @(negedge clk);
        rd(8'h10, v); chk("R5 flag set before collision", v & 32'h400, 32'h400);
        pins[10] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr(8'h10, 32'h400);
        rd(8'h10, v); chk("R5 edge wins over clear", v & 32'h400, 32'h400);
        wr(8'h10, 32'h400);
        rd(8'h10, v); chk("R5 later clear works", v & 32'h400, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule